// File: doc/BRIEF.md
# Reconfigurable Four-Node Neural Cell

This block is a single cell of a grid-style neural network. It owns four signed fixed-point nodes. A 2-bit topology code decides which nodes accept values and which produce them. Each producing node computes a bias plus the weighted sum of all accepting nodes. The result passes through a linear activation that clamps symmetrically at plus and minus one.

Node values are 8-bit signed numbers in Q1.6 format, so 0x40 is +1.0 and 0xC0 is -1.0. Each weight and each bias is a 2-bit code that selects one of four fixed values. The whole weight and bias set arrives as one packed vector.

An operation begins when `start_i` is sampled high. One clock later the registered node values appear, together with a one-cycle `done_o` pulse. The results then hold until the next operation.

Top module: `flex_neuron_cell`

## Requirements
- R1: After reset, `node_o` is all zero and `done_o` is low.
- R2: The topology code selects which nodes are outputs:
  - 0: node 0 is an input; nodes 1, 2 and 3 are outputs.
  - 1: nodes 0, 1 and 2 are inputs; node 3 is an output.
  - 2: nodes 0 and 1 are inputs; nodes 2 and 3 are outputs.
  - 3: nodes 0 and 2 are inputs; nodes 1 and 3 are outputs.
  - Node k occupies bits [8k+7:8k] of `node_i` and of `node_o`.
- R3: The weight from input node i to output node j sits in `coef_i` bits [2*(4j+i)+1 : 2*(4j+i)]. The codes are 00 = -1.0, 01 = -0.5, 10 = +0.5 and 11 = +1.0.
- R4: The bias of output node j sits in `coef_i` bits [33+2j : 32+2j] and uses the same four codes as the weights.
- R5: Before clamping, an output node's value is the floor, in units of 1/64, of the exact bias plus the sum of weight times value over every input node. Input values pass into the sum unchanged. Intermediate sums never wrap.
- R6: Each output node is clamped to the range -64 (0xC0) to +64 (0x40).
- R7: The `node_o` lanes of nodes configured as inputs read zero.
- R8: Some parts of the inputs have no effect on `node_o`:
  - weight codes that do not connect an input node to an output node;
  - bias codes of input nodes;
  - `node_i` lanes of output nodes.
- R9: When `start_i` is sampled high, `node_o` and a one-cycle-high `done_o` appear after that same clock edge. When `start_i` is sampled low, `done_o` is low after the edge.
- R10: While `start_i` is low, `node_o` holds its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch one evaluation |
| type_i | input | 2 | Topology code |
| coef_i | input | 40 | Packed weight codes (32 bits) and bias codes (8 bits) |
| node_i | input | 32 | Four node values, Q1.6 |
| node_o | output | 32 | Four registered node results, Q1.6 |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The assertions check the following on every cycle:
- the start-to-done relationship;
- that results hold while idle;
- that every output lane stays inside the clamp range;
- that lanes belonging to input nodes read zero for the topology that was launched.

The arithmetic itself can only be shown by the bench scenarios. These cover:
- the weight and bias code mapping and its bit layout;
- floor rounding of half-LSB sums;
- saturation at both rails;
- the immunity of the results to unconnected weights and to values on output-node lanes.

// File: rtl/flex_neuron_pkg.sv
package flex_neuron_pkg;
   localparam int NODES   = 4;
   localparam int CODE_W  = 2;
   localparam int WGT_W   = CODE_W * NODES * NODES;
   localparam int COEF_W  = WGT_W + CODE_W * NODES;

   typedef enum logic [1:0] {
      TOPO_FAN_OUT = 2'd0,
      TOPO_FAN_IN  = 2'd1,
      TOPO_SPLIT   = 2'd2,
      TOPO_CROSS   = 2'd3
   } topo_e;

   // bit k set: node k is an output
   function automatic logic [NODES-1:0] out_mask(input logic [1:0] t);
      case (topo_e'(t))
         TOPO_FAN_OUT: return 4'b1110;
         TOPO_FAN_IN:  return 4'b1000;
         TOPO_SPLIT:   return 4'b1100;
         default:      return 4'b1010;
      endcase
   endfunction
endpackage

// File: rtl/flex_neuron_topo.sv
module flex_neuron_topo
   import flex_neuron_pkg::*;
(
   input  logic [1:0]       type_i,
   output logic [NODES-1:0] is_out_o,
   output logic [NODES-1:0] is_in_o
);
   always_comb begin
      is_out_o = out_mask(type_i);
      is_in_o  = ~is_out_o;
   end
endmodule

// File: rtl/flex_neuron_mac.sv
module flex_neuron_mac
   import flex_neuron_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FRAC_W = 6,
   parameter int ACC_W  = DATA_W + 4
) (
   input  logic [NODES*DATA_W-1:0]  nodes_i,
   input  logic [NODES-1:0]         in_mask_i,
   input  logic [NODES*CODE_W-1:0]  wrow_i,
   input  logic [CODE_W-1:0]        bias_i,
   output logic signed [ACC_W-1:0]  acc_o
);
   // accumulator counts half-LSB units
   logic signed [ACC_W-1:0] term [NODES];
   logic signed [ACC_W-1:0] bias_h;
   localparam logic signed [ACC_W-1:0] HALF_ONE = ACC_W'(1) <<< FRAC_W;

   for (genvar i = 0; i < NODES; i++) begin : g_term
      logic signed [ACC_W-1:0] xe;
      assign xe = {{(ACC_W-DATA_W){nodes_i[i*DATA_W+DATA_W-1]}},
                   nodes_i[i*DATA_W +: DATA_W]};
      always_comb begin
         if (!in_mask_i[i]) begin
            term[i] = '0;
         end else begin
            case (wrow_i[i*CODE_W +: CODE_W])
               2'b00:   term[i] = -(xe <<< 1);
               2'b01:   term[i] = -xe;
               2'b10:   term[i] = xe;
               default: term[i] = xe <<< 1;
            endcase
         end
      end
   end

   always_comb begin
      case (bias_i)
         2'b00:   bias_h = -(HALF_ONE <<< 1);
         2'b01:   bias_h = -HALF_ONE;
         2'b10:   bias_h = HALF_ONE;
         default: bias_h = HALF_ONE <<< 1;
      endcase
   end

   always_comb begin
      acc_o = bias_h;
      for (int i = 0; i < NODES; i++) acc_o = acc_o + term[i];
   end
endmodule

// File: rtl/flex_neuron_sat.sv
module flex_neuron_sat #(
   parameter int DATA_W = 8,
   parameter int FRAC_W = 6,
   parameter int ACC_W  = DATA_W + 4
) (
   input  logic signed [ACC_W-1:0]  acc_i,
   output logic [DATA_W-1:0]        val_o
);
   localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1) <<< FRAC_W;
   localparam logic signed [ACC_W-1:0] MONE = -ONE;
   logic signed [ACC_W-1:0] q;

   always_comb begin
      q = acc_i >>> 1;
      if (q > ONE)       val_o = ONE[DATA_W-1:0];
      else if (q < MONE) val_o = MONE[DATA_W-1:0];
      else               val_o = q[DATA_W-1:0];
   end
endmodule

// File: rtl/flex_neuron_cell.sv
module flex_neuron_cell
   import flex_neuron_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FRAC_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [1:0]               type_i,
   input  logic [COEF_W-1:0]        coef_i,
   input  logic [NODES*DATA_W-1:0]  node_i,
   output logic [NODES*DATA_W-1:0]  node_o,
   output logic                     done_o
);
   localparam int ACC_W = DATA_W + 4;

   if (FRAC_W + 2 > DATA_W) begin : g_bad_frac
      $error("flex_neuron_cell: DATA_W must hold +/-1.0 in the chosen FRAC_W");
   end
   if (FRAC_W < 1) begin : g_bad_min
      $error("flex_neuron_cell: FRAC_W must be at least 1");
   end

   logic [NODES-1:0]         is_out, is_in;
   logic [NODES*DATA_W-1:0]  result;

   flex_neuron_topo u_topo (
      .type_i   (type_i),
      .is_out_o (is_out),
      .is_in_o  (is_in)
   );

   for (genvar j = 0; j < NODES; j++) begin : g_node
      logic signed [ACC_W-1:0] acc;
      logic [DATA_W-1:0]       sat;

      flex_neuron_mac #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_mac (
         .nodes_i   (node_i),
         .in_mask_i (is_in),
         .wrow_i    (coef_i[j*NODES*CODE_W +: NODES*CODE_W]),
         .bias_i    (coef_i[WGT_W + j*CODE_W +: CODE_W]),
         .acc_o     (acc)
      );

      flex_neuron_sat #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_sat (
         .acc_i (acc),
         .val_o (sat)
      );

      assign result[j*DATA_W +: DATA_W] = is_out[j] ? sat : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         node_o <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) node_o <= result;
      end
   end
endmodule

// File: rtl/flex_neuron_cell_chk.sv
module flex_neuron_cell_chk
   import flex_neuron_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FRAC_W = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_i,
   input logic [1:0]               type_i,
   input logic [NODES*DATA_W-1:0]  node_o,
   input logic                     done_o
);
   localparam logic signed [DATA_W-1:0] ONE  = DATA_W'(1) <<< FRAC_W;
   localparam logic signed [DATA_W-1:0] MONE = -ONE;

   // R9
   done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);

   // R10
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(node_o));

   for (genvar k = 0; k < NODES; k++) begin : g_lane
      // R6
      lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($signed(node_o[k*DATA_W +: DATA_W]) <= ONE) &&
         ($signed(node_o[k*DATA_W +: DATA_W]) >= MONE));

      // R7
      input_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (start_i && !out_mask(type_i)[k]) |=> (node_o[k*DATA_W +: DATA_W] == '0));
   end
endmodule

bind flex_neuron_cell flex_neuron_cell_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .type_i  (type_i),
   .node_o  (node_o),
   .done_o  (done_o)
);

// File: tb/flex_neuron_cell_tb_top.sv
module flex_neuron_cell_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  type_i = '0;
   logic [39:0] coef_i = '0;
   logic [31:0] node_i = '0;
   logic [31:0] node_o;
   logic        done_o;

   int checks = 0;
   int failures = 0;
   bit ended = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;

   flex_neuron_cell dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .type_i(type_i),
      .coef_i(coef_i), .node_i(node_i), .node_o(node_o), .done_o(done_o)
   );

   function automatic logic [3:0] outs(input logic [1:0] t);
      case (t)
         2'd0: return 4'b1110;
         2'd1: return 4'b1000;
         2'd2: return 4'b1100;
         default: return 4'b1010;
      endcase
   endfunction

   // code value in halves: -2,-1,+1,+2
   function automatic int halves(input logic [1:0] c);
      case (c)
         2'b00: return -2;
         2'b01: return -1;
         2'b10: return 1;
         default: return 2;
      endcase
   endfunction

   function automatic logic [31:0] model(input logic [1:0] t, input logic [39:0] c,
                                         input logic [31:0] n);
      logic [3:0]  om = outs(t);
      logic [31:0] r = '0;
      for (int j = 0; j < 4; j++) begin
         if (om[j]) begin
            int acc2 = halves(c[32+2*j +: 2]) * 64;
            int v;
            for (int i = 0; i < 4; i++)
               if (!om[i]) acc2 += int'($signed(n[8*i +: 8])) * halves(c[2*(4*j+i) +: 2]);
            v = (acc2 < 0) ? -((-acc2 + 1) / 2) : acc2 / 2;  // floor
            if (v > 64) v = 64;
            if (v < -64) v = -64;
            r[8*j +: 8] = 8'(v);
         end
      end
      return r;
   endfunction

   function automatic logic [31:0] nxt();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] t, input logic [39:0] c, input logic [31:0] n);
      @(negedge clk);
      type_i = t; coef_i = c; node_i = n; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp, held;
      logic [39:0] c, c2;
      logic [31:0] n, n2;
      logic [3:0]  om;
      repeat (3) @(negedge clk);
      // R1
      chk(node_o == 0 && done_o == 0, "R1", {31'd0, done_o, node_o}, 64'd0);
      rst_n = 1'b1;

      // R2 R3 R4 R5: sweep of topologies with varied codes and values
      for (int t = 0; t < 4; t++) begin
         for (int k = 0; k < 48; k++) begin
            c = {nxt(), nxt()};
            n = nxt();
            if (k == 0) n = 32'h7F7F_7F7F;
            if (k == 1) n = 32'h8080_8080;
            if (k == 2) n = 32'h4040_4040;
            if (k == 3) n = 32'hC0C0_C0C0;
            if (k == 4) n = 32'h0101_0101;
            run_op(2'(t), c, n);
            exp = model(2'(t), c, n);
            chk(node_o == exp, "R2/R3/R4/R5", {32'd0, node_o}, {32'd0, exp});
            // R9
            chk(done_o == 1'b1, "R9 done pulse", {63'd0, done_o}, 64'd1);
            // R7
            om = outs(2'(t));
            for (int i = 0; i < 4; i++)
               if (!om[i]) chk(node_o[8*i +: 8] == 0, "R7", {56'd0, node_o[8*i +: 8]}, 64'd0);
         end
      end

      // R6: positive rail, topology 1, all +1 weights and bias
      run_op(2'd1, 40'hFF_FFFF_FFFF, 32'h007F_7F7F);
      chk(node_o == 32'h4000_0000, "R6 upper", {32'd0, node_o}, 64'h4000_0000);
      // R6: negative rail
      run_op(2'd1, 40'h00_FFFF_FFFF, 32'h0080_8080);
      chk(node_o == 32'hC000_0000, "R6 lower", {32'd0, node_o}, 64'hC000_0000);

      // R5 floor: node0=1, w(0->3)=+0.5, bias(3)=-0.5 -> -31.5 -> -32
      c = '0; c[2*12 +: 2] = 2'b10; c[38 +: 2] = 2'b01;
      run_op(2'd1, c, 32'h0000_0001);
      chk(node_o == 32'hE000_0000, "R5 floor", {32'd0, node_o}, 64'hE000_0000);
      // R5 exact: 0.5 input * +1 with bias -0.5 -> 0
      c = '0; c[2*12 +: 2] = 2'b11; c[38 +: 2] = 2'b01;
      run_op(2'd1, c, 32'h0000_0020);
      chk(node_o == 32'h0000_0000, "R5 zero", {32'd0, node_o}, 64'd0);

      // R8: disconnected codes and output-lane values do not matter
      for (int t = 0; t < 4; t++) begin
         for (int k = 0; k < 6; k++) begin
            c = {nxt(), nxt()}; n = nxt();
            om = outs(2'(t));
            c2 = c; n2 = n;
            for (int j = 0; j < 4; j++) begin
               if (!om[j]) begin
                  c2[32+2*j +: 2] = ~c[32+2*j +: 2];
                  for (int i = 0; i < 4; i++) c2[2*(4*j+i) +: 2] = nxt()[1:0];
               end else begin
                  n2[8*j +: 8] = ~n[8*j +: 8];
                  for (int i = 0; i < 4; i++)
                     if (om[i]) c2[2*(4*j+i) +: 2] = ~c[2*(4*j+i) +: 2];
               end
            end
            run_op(2'(t), c2, n2);
            exp = model(2'(t), c, n);
            chk(node_o == exp, "R8", {32'd0, node_o}, {32'd0, exp});
         end
      end

      // R9 R10: idle cycles with changing inputs
      held = node_o;
      @(negedge clk);
      type_i = ~type_i; coef_i = ~coef_i; node_i = ~node_i;
      chk(done_o == 1'b0, "R9 done low", {63'd0, done_o}, 64'd0);
      @(negedge clk);
      chk(node_o == held, "R10 hold", {32'd0, node_o}, {32'd0, held});
      @(negedge clk);
      chk(node_o == held, "R10 hold2", {32'd0, node_o}, {32'd0, held});

      // R1: reset again clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      chk(node_o == 0 && done_o == 0, "R1 re-reset", {31'd0, done_o, node_o}, 64'd0);

      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule